// File: doc/BRIEF.md
# Response Buffer Drain Sequencer

This block retires one read-response buffer at a time without losing data that is still in flight. It watches a live status vector, which carries an in-use flag and a data-present flag for every buffer. It waits until the chosen buffer has no outstanding transactions. If the buffer still holds data, it fires a one-hot clear strobe. It then waits until the data-present flag drops, and finally reports completion with a one-cycle done pulse.

Three operations share the sequencer. A plain clear drains the named buffer and leaves the ownership map alone. A flush first reads the ownership map word that covers the buffer and disables the buffer's enable bit for the duration of the drain. After the drain it writes the original word back. A device sweep scans one map word for every buffer that is enabled and owned by a given device bit, whatever its channel bits. It flushes the matches one after another, from the lowest nibble upward. An optional timeout abandons a wait phase that takes too long and flags an error. Even then, the saved map word is put back.

Top module: `rsp_drain_seq`

## Requirements
- R1: After reset, busy, done, err, clr_pulse and map_wr_en are all 0.
- R2: While status bit r (in-use of buffer r) is 1, the block waits and issues no clear. For op 00 the first check is at the edge after the accepting edge. Only buffer r's bits matter.
- R3: If status bit NBUF+r (data present) is 1 at the edge where in-use is first seen 0, clr_pulse equals 1<<r for the next cycle only. From two edges later the block waits for that bit to be seen 0, and raises done in the cycle after.
- R4: If status bit NBUF+r is 0 when the in-use wait ends, no clear is issued, and done (or the restore write) follows in the next cycle.
- R5: Flush (op 01) behaves as follows. In the cycle after acceptance, it reads map word r[0], whose enable bit for buffer r sits at bit 4*(r>>1)+3. If that bit is set, the next cycle writes the same word with only that bit cleared, and the in-use wait starts one edge later. If the bit is clear, no write is made and the wait starts at the edge after the read.
- R6: A flush whose enable bit was set writes the saved word back in the cycle after the drain ends, and raises done the cycle after that.
- R7: Sweep (op 1x) takes tgt[0] as the map word and tgt[1] as the device value. It flushes, in ascending nibble order, every nibble whose bit 3 is 1 and whose bit 0 equals the device value, ignoring bits 2:1. Each match is buffer 2*nibble+tgt[0]. One done pulse ends the sweep.
- R8: With tmo_limit nonzero, a wait phase still pending tmo_limit edges after its first check is abandoned. Any saved map word is restored, and done is raised with err at 1. A limit of 0 disables the timeout. err returns to 0 when the next operation is accepted.
- R9: start is ignored while busy is 1.
- R10: done lasts exactly one cycle. busy is 1 from the cycle after acceptance through the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new operation (taken when idle) |
| op | input | 2 | 00 clear, 01 flush, 1x device sweep |
| tgt | input | 4 | Buffer number, or word select and device value for a sweep |
| tmo_limit | input | 8 | Wait-phase cycle limit, 0 disables |
| status | input | 32 | In-use flags at bits 15:0, data-present flags at bits 31:16 |
| map_rd_sel | output | 1 | Map word selected for reading |
| map_rd_data | input | 32 | Selected map word, combinational |
| map_wr_en | output | 1 | Map write strobe |
| map_wr_sel | output | 1 | Map word to write |
| map_wr_data | output | 32 | Map write value |
| clr_pulse | output | 16 | One-hot clear command |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished |
| err | output | 1 | Last operation ended by timeout |

## Verification
For a clear, the first in-use check is at the edge after acceptance. A flush adds one edge for the map read and one more when a disable write is needed. The clear strobe appears in the cycle after the edge that sees in-use low. The data-present wait begins two edges later, and done follows the edge that sees that flag low, one cycle later still when a restore write is due. The bench drives the status vector as a reactive model sampled at falling edges. From each vector's fields it computes these exact cycle numbers and compares the cycle in which each clear, write and done was seen against them.

// File: rtl/drain_pkg.sv
package drain_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SCAN,
      ST_RDMAP,
      ST_DIS,
      ST_WUSE,
      ST_CLR,
      ST_WVAL,
      ST_REST,
      ST_FIN
   } drain_st_e;

   // operation codes; any code with bit 1 set is a device sweep
   localparam logic [1:0] OP_CLEAR = 2'b00;
   localparam logic [1:0] OP_FLUSH = 2'b01;
endpackage

// File: rtl/drain_pick.sv
// Finds the lowest nibble at or above from_idx whose enable bit is set and
// whose device bit equals dev_val. Channel bits do not take part.
module drain_pick #(
   parameter int NIBS    = 8,
   parameter int NIB_W   = 4,
   parameter int EN_POS  = 3,
   parameter int DEV_POS = 0,
   localparam int MAP_W  = NIBS * NIB_W,
   localparam int IDX_W  = $clog2(NIBS),
   localparam int PTR_W  = IDX_W + 1
) (
   input  logic [MAP_W-1:0] word,
   input  logic             dev_val,
   input  logic [PTR_W-1:0] from_idx,
   output logic             hit,
   output logic [IDX_W-1:0] idx
);
   logic [NIBS-1:0] match;
   logic            unused_word;

   assign unused_word = ^word;

   for (genvar g = 0; g < NIBS; g++) begin : g_nib
      assign match[g] = word[g*NIB_W + EN_POS]
                     && (word[g*NIB_W + DEV_POS] == dev_val)
                     && (PTR_W'(g) >= from_idx);
   end

   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = NIBS - 1; i >= 0; i--) begin
         if (match[i]) begin
            hit = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/drain_tmo.sv
// Wait-phase watchdog. The count restarts whenever the sequencer is not
// waiting; expired rises once a pending wait has lasted limit edges.
module drain_tmo #(
   parameter int TMO_W  = 8,
   parameter bit TMO_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             waiting,
   input  logic [TMO_W-1:0] limit,
   output logic             expired
);
   if (TMO_EN) begin : g_on
      logic [TMO_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cnt_q <= '0;
         else if (!waiting)       cnt_q <= '0;
         else if (cnt_q != limit) cnt_q <= cnt_q + 1'b1;
      end

      assign expired = waiting && (limit != '0) && (cnt_q == limit);

      // R8: a timeout can only be reported while a wait is in progress
      a_r8_expire_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
         expired |-> $past(waiting));
   end else begin : g_off
      logic unused_tmo;
      assign unused_tmo = ^{clk, rst_n, waiting, limit};
      assign expired    = 1'b0;
   end
endmodule

// File: rtl/rsp_drain_seq.sv
module rsp_drain_seq
   import drain_pkg::*;
#(
   parameter int NBUF    = 16,
   parameter int NIB_W   = 4,
   parameter int EN_POS  = 3,
   parameter int DEV_POS = 0,
   parameter int TMO_W   = 8,
   parameter bit TMO_EN  = 1'b1,
   localparam int NMAP   = 2,
   localparam int NIBS   = NBUF / NMAP,
   localparam int MAP_W  = NIBS * NIB_W,
   localparam int BUF_W  = $clog2(NBUF),
   localparam int IDX_W  = $clog2(NIBS),
   localparam int PTR_W  = IDX_W + 1,
   localparam int STAT_W = 2 * NBUF,
   localparam int POS_W  = $clog2(MAP_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic [BUF_W-1:0]  tgt,
   input  logic [TMO_W-1:0]  tmo_limit,
   input  logic [STAT_W-1:0] status,
   output logic              map_rd_sel,
   input  logic [MAP_W-1:0]  map_rd_data,
   output logic              map_wr_en,
   output logic              map_wr_sel,
   output logic [MAP_W-1:0]  map_wr_data,
   output logic [NBUF-1:0]   clr_pulse,
   output logic              busy,
   output logic              done,
   output logic              err
);
   // elaboration-time parameter checks
   if ((NBUF < 4) || ((NBUF & (NBUF - 1)) != 0)) begin : g_bad_nbuf
      $error("NBUF must be a power of two, at least 4");
   end
   if ((EN_POS >= NIB_W) || (DEV_POS >= NIB_W) || (EN_POS == DEV_POS)) begin : g_bad_pos
      $error("EN_POS and DEV_POS must be distinct bits inside a nibble");
   end
   if (TMO_W < 1) begin : g_bad_tmo
      $error("TMO_W must be at least 1");
   end

   drain_st_e         st_q, st_d;
   logic [BUF_W-1:0]  cur_q;
   logic [MAP_W-1:0]  saved_q;
   logic              en_was_q;
   logic              sweep_q;
   logic              dev_q;
   logic [PTR_W-1:0]  ptr_q;
   logic              tmo_q;
   logic              err_q;

   logic [IDX_W-1:0]  nib;
   logic [POS_W-1:0]  en_pos;
   logic [MAP_W-1:0]  en_mask;
   logic              inuse_now;
   logic              valid_now;
   logic              waiting;
   logic              expired;
   logic              abort;
   logic              pick_hit;
   logic [IDX_W-1:0]  pick_idx;
   drain_st_e         post_drain;
   drain_st_e         post_abort;

   // where buffer cur_q lives in the map and in the status vector
   assign nib       = cur_q[BUF_W-1:1];
   assign en_pos    = POS_W'(int'(nib) * NIB_W + EN_POS);
   assign en_mask   = MAP_W'(1) << en_pos;
   assign inuse_now = status[{1'b0, cur_q}];
   assign valid_now = status[{1'b1, cur_q}];
   assign waiting   = (st_q == ST_WUSE) || (st_q == ST_WVAL);

   drain_pick #(
      .NIBS    (NIBS),
      .NIB_W   (NIB_W),
      .EN_POS  (EN_POS),
      .DEV_POS (DEV_POS)
   ) u_pick (
      .word     (map_rd_data),
      .dev_val  (dev_q),
      .from_idx (ptr_q),
      .hit      (pick_hit),
      .idx      (pick_idx)
   );

   drain_tmo #(
      .TMO_W  (TMO_W),
      .TMO_EN (TMO_EN)
   ) u_tmo (
      .clk     (clk),
      .rst_n   (rst_n),
      .waiting (waiting),
      .limit   (tmo_limit),
      .expired (expired)
   );

   always_comb begin
      if (en_was_q)     post_drain = ST_REST;
      else if (sweep_q) post_drain = ST_SCAN;
      else              post_drain = ST_FIN;
      post_abort = en_was_q ? ST_REST : ST_FIN;
   end

   always_comb begin
      st_d  = st_q;
      abort = 1'b0;
      unique case (st_q)
         ST_IDLE:  if (start) begin
                      if (op[1])               st_d = ST_SCAN;
                      else if (op == OP_FLUSH) st_d = ST_RDMAP;
                      else                     st_d = ST_WUSE;
                   end
         ST_SCAN:  st_d = pick_hit ? ST_RDMAP : ST_FIN;
         ST_RDMAP: st_d = map_rd_data[en_pos] ? ST_DIS : ST_WUSE;
         ST_DIS:   st_d = ST_WUSE;
         ST_WUSE:  if (!inuse_now) begin
                      st_d = valid_now ? ST_CLR : post_drain;
                   end else if (expired) begin
                      abort = 1'b1;
                      st_d  = post_abort;
                   end
         ST_CLR:   st_d = ST_WVAL;
         ST_WVAL:  if (!valid_now) begin
                      st_d = post_drain;
                   end else if (expired) begin
                      abort = 1'b1;
                      st_d  = post_abort;
                   end
         ST_REST:  st_d = (sweep_q && !tmo_q) ? ST_SCAN : ST_FIN;
         ST_FIN:   st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         cur_q    <= '0;
         saved_q  <= '0;
         en_was_q <= 1'b0;
         sweep_q  <= 1'b0;
         dev_q    <= 1'b0;
         ptr_q    <= '0;
         tmo_q    <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         st_q <= st_d;
         case (st_q)
            ST_IDLE: if (start) begin
               cur_q    <= tgt;
               sweep_q  <= op[1];
               dev_q    <= tgt[1];
               ptr_q    <= '0;
               en_was_q <= 1'b0;
               tmo_q    <= 1'b0;
               err_q    <= 1'b0;
            end
            ST_SCAN: if (pick_hit) begin
               cur_q <= {pick_idx, cur_q[0]};
               ptr_q <= PTR_W'(pick_idx) + 1'b1;
            end
            ST_RDMAP: begin
               saved_q  <= map_rd_data;
               en_was_q <= map_rd_data[en_pos];
            end
            default: ;
         endcase
         if (abort) tmo_q <= 1'b1;
         if ((st_d == ST_FIN) && (st_q != ST_FIN) && (tmo_q || abort)) err_q <= 1'b1;
      end
   end

   assign busy        = (st_q != ST_IDLE);
   assign done        = (st_q == ST_FIN);
   assign err         = err_q;
   assign clr_pulse   = (st_q == ST_CLR) ? (NBUF'(1) << cur_q) : '0;
   assign map_rd_sel  = cur_q[0];
   assign map_wr_sel  = cur_q[0];
   assign map_wr_en   = (st_q == ST_DIS) || (st_q == ST_REST);
   assign map_wr_data = (st_q == ST_DIS) ? (saved_q & ~en_mask) : saved_q;

   // R2: no clear is issued to a buffer that was still in use at the deciding edge
   a_r2_no_clr_in_use: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pulse != '0) |-> ((clr_pulse & $past(status[NBUF-1:0])) == '0));

   // R3: the clear strobe is one-hot or idle
   a_r3_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_pulse));

   // R3, R4: a clear targets only a buffer that held data at the deciding edge
   a_r3_clr_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pulse != '0) |-> ((clr_pulse & $past(status[STAT_W-1:NBUF])) == clr_pulse));

   // R10: done is a single-cycle pulse followed by idle
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R10: busy holds until done
   a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   // R8: an error flag appears together with done
   a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> done);

   // R3: a clear is never issued in two consecutive cycles
   a_r3_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pulse != '0) |=> (clr_pulse == '0));
endmodule

// File: tb/sim_rsp_drain_seq.sv
`timescale 1ns/1ps
module sim_rsp_drain_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'd0;
   logic [3:0]  tgt = 4'd0;
   logic [7:0]  tmo_limit = 8'd0;
   logic [31:0] status = 32'd0;
   logic        map_rd_sel;
   logic [31:0] map_rd_data;
   logic        map_wr_en;
   logic        map_wr_sel;
   logic [31:0] map_wr_data;
   logic [15:0] clr_pulse;
   logic        busy, done, err;

   always #2.5 clk = ~clk;

   // map register model: loaded by the bench, written by the design
   logic [31:0] mapm [2];
   logic        load_en = 1'b0;
   logic [31:0] ld0 = 32'd0, ld1 = 32'd0;
   assign map_rd_data = mapm[map_rd_sel];
   always @(posedge clk) begin
      if (load_en) begin
         mapm[0] <= ld0;
         mapm[1] <= ld1;
      end else if (map_wr_en) begin
         mapm[map_wr_sel] <= map_wr_data;
      end
   end

   rsp_drain_seq u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .tgt(tgt),
      .tmo_limit(tmo_limit), .status(status), .map_rd_sel(map_rd_sel),
      .map_rd_data(map_rd_data), .map_wr_en(map_wr_en), .map_wr_sel(map_wr_sel),
      .map_wr_data(map_wr_data), .clr_pulse(clr_pulse), .busy(busy),
      .done(done), .err(err)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // observations of one run
   int          o_done_c, o_clr_c, o_nclr, o_nwr, o_ndone;
   logic [15:0] o_clr_val;
   logic [31:0] o_wr0, o_orig, o_other;
   logic        o_err;

   // fields: op[15:14] tgt[13:10] inuse_cycles[9:6] has_data[5] drain_cycles[4:1] enable[0]
   localparam int NV = 8;
   localparam logic [15:0] VEC [NV] = '{
      {2'd0, 4'd5,  4'd0, 1'b1, 4'd2, 1'b0},
      {2'd0, 4'd12, 4'd3, 1'b1, 4'd0, 1'b0},
      {2'd0, 4'd0,  4'd2, 1'b0, 4'd0, 1'b0},
      {2'd1, 4'd7,  4'd1, 1'b1, 4'd1, 1'b1},
      {2'd1, 4'd10, 4'd0, 1'b0, 4'd0, 1'b1},
      {2'd1, 4'd15, 4'd4, 1'b1, 4'd3, 1'b0},
      {2'd1, 4'd2,  4'd0, 1'b1, 4'd0, 1'b1},
      {2'd0, 4'd9,  4'd5, 1'b1, 4'd5, 1'b0}
   };

   task automatic load_maps(input logic [31:0] w0, input logic [31:0] w1);
      @(negedge clk);
      ld0 = w0; ld1 = w1; load_en = 1'b1;
      @(negedge clk);
      load_en = 1'b0;
   endtask

   // one operation against a reactive status model
   task automatic run(input logic [1:0] op_i, input logic [3:0] tgt_i, input int u,
                      input bit hasv, input int v, input bit en, input bit stuck,
                      input logic [7:0] lim, input bit poke);
      logic [31:0] base;
      int pos, c, vdrop;
      bit seen;
      base = 32'h3A5C61E4 ^ {8{tgt_i}};
      pos = int'(tgt_i >> 1) * 4 + 3;
      if (en) o_orig = base | (32'd1 << pos);
      else    o_orig = base & ~(32'd1 << pos);
      o_other = 32'h0F0F0F0F;
      if (tgt_i[0]) load_maps(o_other, o_orig);
      else          load_maps(o_orig, o_other);
      o_done_c = -1; o_clr_c = -1; o_nclr = 0; o_nwr = 0; o_ndone = 0;
      o_clr_val = '0; o_wr0 = '0; o_err = 1'b0;
      seen = 1'b0; vdrop = 0;
      tmo_limit = lim;
      status = 32'd0;
      status[(tgt_i + 4'd1)] = 1'b1;          // unrelated buffer busy and full
      status[16 + int'(tgt_i + 4'd1)] = 1'b1;
      status[tgt_i] = 1'b1;
      status[16 + int'(tgt_i)] = hasv;
      op = op_i; tgt = tgt_i; start = 1'b1;
      c = 0;
      while (c < 120 && (o_done_c < 0 || c <= o_done_c + 4)) begin
         @(negedge clk);
         start = 1'b0;
         if (clr_pulse != '0) begin
            o_nclr++;
            o_clr_c = c;
            o_clr_val = clr_pulse;
            if (!seen) vdrop = c + v;
            seen = 1'b1;
         end
         if (map_wr_en) begin
            if (o_nwr == 0) o_wr0 = map_wr_data;
            o_nwr++;
         end
         if (done) begin
            o_ndone++;
            if (o_done_c < 0) begin
               o_done_c = c;
               o_err = err;
            end
         end
         status[tgt_i] = stuck || (c + 1 <= u);
         status[16 + int'(tgt_i)] = hasv && (!seen || (c + 1 <= vdrop));
         if (poke && c == 1) begin
            start = 1'b1; op = 2'd1; tgt = 4'd8;
         end
         c++;
      end
      status = 32'd0;
   endtask

   task automatic judge(input string nm, input logic [1:0] op_i, input logic [3:0] tgt_i,
                        input int u, input bit hasv, input int v, input bit en);
      int f, w, x, exp_done, exp_wr;
      bit rest;
      rest = (op_i == 2'd1) && en;
      f = (op_i == 2'd0) ? 1 : (en ? 3 : 2);
      w = (u + 1 > f) ? u + 1 : f;
      x = hasv ? w + 1 + ((v > 1) ? v : 1) : w;
      exp_done = x + (rest ? 1 : 0);
      exp_wr = rest ? 2 : 0;
      chk(o_done_c == exp_done, {nm, " R2 R3 done cycle"}, o_done_c, exp_done);
      chk(o_ndone == 1, {nm, " R10 single done"}, o_ndone, 1);
      if (hasv) begin
         chk(o_nclr == 1, {nm, " R3 clear count"}, o_nclr, 1);
         chk(o_clr_c == w, {nm, " R2 R3 clear cycle"}, o_clr_c, w);
         chk(o_clr_val == (16'd1 << tgt_i), {nm, " R3 clear one-hot"}, o_clr_val, 16'd1 << tgt_i);
      end else begin
         chk(o_nclr == 0, {nm, " R4 no clear without data"}, o_nclr, 0);
      end
      chk(o_nwr == exp_wr, {nm, " R5 map write count"}, o_nwr, exp_wr);
      if (rest)
         chk(o_wr0 == (o_orig & ~(32'd1 << (int'(tgt_i >> 1) * 4 + 3))), {nm, " R5 disable write"},
             o_wr0, o_orig & ~(32'd1 << (int'(tgt_i >> 1) * 4 + 3)));
      chk(mapm[tgt_i[0]] == o_orig, {nm, " R6 map restored"}, mapm[tgt_i[0]], o_orig);
      chk(mapm[~tgt_i[0]] == o_other, {nm, " R6 other map untouched"}, mapm[~tgt_i[0]], o_other);
      chk(o_err == 1'b0, {nm, " R8 no error"}, o_err, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk({busy, done, err, map_wr_en, |clr_pulse} == 5'b0, "R1 reset outputs",
          {busy, done, err, map_wr_en, |clr_pulse}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, done, err} == 3'b0, "R1 idle after reset", {busy, done, err}, 0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         run(VEC[i][15:14], VEC[i][13:10], int'(VEC[i][9:6]), VEC[i][5], int'(VEC[i][4:1]),
             VEC[i][0], 1'b0, 8'd0, 1'b0);
         judge($sformatf("vec%0d", i), VEC[i][15:14], VEC[i][13:10], int'(VEC[i][9:6]),
               VEC[i][5], int'(VEC[i][4:1]), VEC[i][0]);
      end

      // R9: a second start while busy is ignored
      run(2'd0, 4'd4, 3, 1'b1, 1, 1'b0, 1'b0, 8'd0, 1'b1);
      judge("busy", 2'd0, 4'd4, 3, 1'b1, 1, 1'b0);
      chk(o_ndone == 1 && o_nwr == 0, "R9 start ignored while busy", o_ndone, 1);

      // R8: clear stuck in use, limit 5
      run(2'd0, 4'd3, 0, 1'b1, 1, 1'b0, 1'b1, 8'd5, 1'b0);
      chk(o_done_c == 6, "R8 timeout done cycle", o_done_c, 6);
      chk(o_err == 1'b1, "R8 timeout flags err", o_err, 1);
      chk(o_nclr == 0, "R8 R2 no clear while stuck", o_nclr, 0);

      // R8: flush stuck in use, limit 4, enable restored
      run(2'd1, 4'd6, 0, 1'b1, 1, 1'b1, 1'b1, 8'd4, 1'b0);
      chk(o_done_c == 8, "R8 flush timeout done cycle", o_done_c, 8);
      chk(o_err == 1'b1, "R8 flush timeout err", o_err, 1);
      chk(o_nwr == 2, "R8 R6 restore after timeout", o_nwr, 2);
      chk(mapm[0] == o_orig, "R8 R6 map after timeout", mapm[0], o_orig);

      // R8: in-use drops before the limit; err cleared by the new start
      run(2'd0, 4'd11, 2, 1'b0, 0, 1'b0, 1'b0, 8'd3, 1'b0);
      chk(o_done_c == 3, "R8 R4 done before limit", o_done_c, 3);
      chk(o_err == 1'b0 && err == 1'b0, "R8 err cleared", o_err, 0);

      // R7: device sweep over word 1, device value 1
      begin
         int seq [8];
         int n, c, nd;
         logic [15:0] vmask;
         load_maps(32'h99999999, 32'hDA1BF789);
         vmask = 16'hFFFF;
         status = {vmask, 16'h0000};
         tmo_limit = 8'd0;
         op = 2'd2; tgt = 4'b0011; start = 1'b1;
         n = 0; nd = 0; c = 0;
         while (c < 400 && nd == 0) begin
            @(negedge clk);
            start = 1'b0;
            if (clr_pulse != '0) begin
               for (int b = 0; b < 16; b++) if (clr_pulse[b] && n < 8) begin seq[n] = b; n++; end
               vmask = vmask & ~clr_pulse;
            end
            if (done) nd++;
            status = {vmask, 16'h0000};
            c++;
         end
         chk(n == 4, "R7 sweep match count", n, 4);
         chk(n > 0 && seq[0] == 1, "R7 sweep first buffer", seq[0], 1);
         chk(n > 1 && seq[1] == 7, "R7 sweep second buffer", seq[1], 7);
         chk(n > 2 && seq[2] == 9, "R7 sweep third buffer", seq[2], 9);
         chk(n > 3 && seq[3] == 15, "R7 sweep fourth buffer", seq[3], 15);
         chk(nd == 1, "R7 R10 sweep single done", nd, 1);
         chk(mapm[1] == 32'hDA1BF789, "R7 R6 swept word restored", mapm[1], 32'hDA1BF789);
         chk(mapm[0] == 32'h99999999, "R7 other word untouched", mapm[0], 32'h99999999);
         @(negedge clk);
         chk(busy == 1'b0, "R10 idle after sweep", busy, 0);
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule